// File: doc/BRIEF.md
# Arbiter PUF Delay-Model Emulator

This block is a cycle-stepped, synthesizable model of a multiplexer-chain arbiter PUF. The manufacturing spread of a real chain is replaced by a table of signed per-stage delay differences that software writes through an indexed port, one value per stage. After a start request, the block walks the chain at one stage per clock. Each stage adds its stored difference to a running total when its select bit is 0 and subtracts it when the select bit is 1. The final arbiter returns 1 when the total is zero or positive and 0 when it is negative.

A two-bit mode chooses the chain topology for each evaluation:
- **Plain chain.** Every stage is selected by its challenge bit.
- **Feed-forward.** An intermediate arbiter samples the sign of the partial total at a tap stage. That decision then drives the selects of a contiguous destination window, and the challenge bits of those stages are ignored.
- **Stage skipping.** Stages flagged in a mask are bypassed and add nothing to the total.

The challenge, the mode, the tap, the window and the mask are captured when a start is accepted. The accumulated total is exposed next to the response so that the margin of each decision can be observed.

Top module: `arb_puf_emu`

## Requirements
- R1: After reset, busy, done and response are 0 and delaySum is 0. Every stage delay reads as 0.
- R2: With mode 0 (plain), or with mode 3 (treated as plain), delaySum equals the sum over all stages i of d[i] when challenge[i] is 0, and of -d[i] when challenge[i] is 1. Bit i of challenge belongs to stage i.
- R3: response is 1 when delaySum is zero or positive and 0 when it is negative. This includes an exact total of 0.
- R4: A start accepted while idle raises busy at the next edge. done pulses high for exactly one cycle, NUM_STAGES cycles after the accepting edge. In that cycle busy is low and response and delaySum are valid.
- R5: A start that arrives while busy is ignored: the run is not restarted and no extra done pulse follows.
- R6: With mode 1 (feed-forward), the decision taken after the tap stage has been added (1 when the partial total is at least 0) is the select for every stage from ffLo to ffHi inclusive. The challenge bits of those stages have no effect.
- R7: In mode 1, if ffLo is not greater than tapIdx, or if ffHi is less than ffLo, the run is computed as a plain chain.
- R8: With mode 2 (skip), every stage whose skipMask bit is 1 contributes 0, whatever its delay and its challenge bit.
- R9: A write with wrEn high while idle stores wrData as the two's-complement delay of stage wrIdx. A write while busy is ignored.
- R10: The total cannot overflow. With every delay at -32768 and every challenge bit at 1, delaySum is +2097152 for 64 stages.
- R11: Challenge, mode, tap, window and mask are sampled when the start is accepted. Changes to them during a run have no effect. While idle with no start, response and delaySum hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Stage delay write strobe |
| wrIdx | input | IDX_W | Stage index written |
| wrData | input | DELAY_W | Signed stage delay difference |
| start | input | 1 | Evaluation request |
| challenge | input | NUM_STAGES | Per-stage select bits |
| mode | input | 2 | 0 plain, 1 feed-forward, 2 skip, 3 plain |
| tapIdx | input | IDX_W | Stage whose partial sign feeds forward |
| ffLo | input | IDX_W | First stage of feed-forward window |
| ffHi | input | IDX_W | Last stage of feed-forward window |
| skipMask | input | NUM_STAGES | Stages bypassed in skip mode |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | One-cycle result strobe |
| response | output | 1 | Arbiter decision |
| delaySum | output | ACC_W | Final signed delay total |

## Verification
The bench targets the following corner cases. A total of exactly zero must read as 1; a design that tests for strictly positive would return 0. A feed-forward run whose tap decision is negative must flip the window stages back to addition; wiring the window to the challenge instead would give -64 where 62 is expected. A destination window that starts at or before its tap must degrade to the plain total rather than use a stale decision. Full-scale negative delays under all-ones challenges must produce the positive extreme; a sum that negates at 16 bits or uses an accumulator one bit too narrow would wrap it negative. Mid-run restarts, configuration changes and writes are issued to show that a design which re-samples inputs or accepts writes while busy would corrupt the result or pulse done twice.

// File: rtl/arb_puf_emu_pkg.sv
package arb_puf_emu_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_FFWD  = 2'd1,
    MODE_SKIP  = 2'd2,
    MODE_RSVD  = 2'd3
  } chainMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic running;  // a run is in progress
    logic capture;  // accept start, latch config, clear accumulator
    logic step;     // process the stage at stageIdx
    logic last;     // the stage at stageIdx is the final one
  } ctrlStrobe_t;

endpackage

// File: rtl/arb_puf_emu_ctrl.sv
module arb_puf_emu_ctrl
  import arb_puf_emu_pkg::*;
#(
  parameter int NUM_STAGES = 64,
  parameter int IDX_W      = $clog2(NUM_STAGES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output ctrlStrobe_t      strobe,
  output logic [IDX_W-1:0] stageIdx,
  output logic             busy,
  output logic             done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STAGES - 1);

  logic             runQ;
  logic [IDX_W-1:0] cntQ;
  logic             doneQ;

  always_comb begin
    strobe.running = runQ;
    strobe.capture = start && !runQ;
    strobe.step    = runQ;
    strobe.last    = runQ && (cntQ == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ  <= 1'b0;
      cntQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= strobe.last;
      if (strobe.capture) begin
        runQ <= 1'b1;
        cntQ <= '0;
      end else if (runQ) begin
        if (strobe.last) begin
          runQ <= 1'b0;
          cntQ <= '0;
        end else begin
          cntQ <= cntQ + 1'b1;
        end
      end
    end
  end

  assign stageIdx = cntQ;
  assign busy     = runQ;
  assign done     = doneQ;

endmodule

// File: rtl/arb_puf_emu_dp.sv
module arb_puf_emu_dp
  import arb_puf_emu_pkg::*;
#(
  parameter int NUM_STAGES = 64,
  parameter int DELAY_W    = 16,
  parameter int IDX_W      = $clog2(NUM_STAGES),
  parameter int ACC_W      = DELAY_W + IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [IDX_W-1:0]        stageIdx,
  input  logic                    wrEn,
  input  logic [IDX_W-1:0]        wrIdx,
  input  logic signed [DELAY_W-1:0] wrData,
  input  logic [NUM_STAGES-1:0]   challenge,
  input  logic [1:0]              mode,
  input  logic [IDX_W-1:0]        tapIdx,
  input  logic [IDX_W-1:0]        ffLo,
  input  logic [IDX_W-1:0]        ffHi,
  input  logic [NUM_STAGES-1:0]   skipMask,
  output logic                    response,
  output logic signed [ACC_W-1:0] delaySum
);

  // per-stage delay table, one register per stage
  logic signed [DELAY_W-1:0] delayTab [NUM_STAGES];

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN)
        delayTab[g] <= '0;
      else if (wrEn && !strobe.running && (wrIdx == IDX_W'(g)))
        delayTab[g] <= wrData;
    end
  end

  // configuration latched at capture
  logic [NUM_STAGES-1:0] chQ;
  logic [NUM_STAGES-1:0] skipQ;
  logic [IDX_W-1:0]      tapQ, loQ, hiQ;
  logic                  ffOkQ, skipOnQ;
  logic                  ffOkNext;

  assign ffOkNext = (chainMode_t'(mode) == MODE_FFWD) && (ffLo > tapIdx) && (ffHi >= ffLo);

  // running state
  logic signed [ACC_W-1:0] accQ;
  logic                    ffBitQ;

  // stage evaluation
  logic signed [DELAY_W-1:0] curDelay;
  logic signed [ACC_W-1:0]   extDelay;
  logic signed [ACC_W-1:0]   contrib;
  logic signed [ACC_W-1:0]   accNext;
  logic                      inWindow;
  logic                      stageSel;
  logic                      stageOff;
  logic                      signNext;

  always_comb begin
    curDelay = delayTab[stageIdx];
    extDelay = ACC_W'(curDelay);
    inWindow = ffOkQ && (stageIdx >= loQ) && (stageIdx <= hiQ);
    stageSel = inWindow ? ffBitQ : chQ[stageIdx];
    stageOff = skipOnQ && skipQ[stageIdx];
    if (stageOff)
      contrib = '0;
    else if (stageSel)
      contrib = -extDelay;
    else
      contrib = extDelay;
    accNext  = accQ + contrib;
    signNext = !accNext[ACC_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chQ      <= '0;
      skipQ    <= '0;
      tapQ     <= '0;
      loQ      <= '0;
      hiQ      <= '0;
      ffOkQ    <= 1'b0;
      skipOnQ  <= 1'b0;
      accQ     <= '0;
      ffBitQ   <= 1'b0;
      response <= 1'b0;
      delaySum <= '0;
    end else if (strobe.capture) begin
      chQ     <= challenge;
      skipQ   <= skipMask;
      tapQ    <= tapIdx;
      loQ     <= ffLo;
      hiQ     <= ffHi;
      ffOkQ   <= ffOkNext;
      skipOnQ <= (chainMode_t'(mode) == MODE_SKIP);
      accQ    <= '0;
      ffBitQ  <= 1'b0;
    end else if (strobe.step) begin
      accQ <= accNext;
      if (stageIdx == tapQ)
        ffBitQ <= signNext;
      if (strobe.last) begin
        response <= signNext;
        delaySum <= accNext;
      end
    end
  end

endmodule

// File: rtl/arb_puf_emu.sv
module arb_puf_emu
  import arb_puf_emu_pkg::*;
#(
  parameter int NUM_STAGES = 64,
  parameter int DELAY_W    = 16,
  parameter int IDX_W      = $clog2(NUM_STAGES),
  parameter int ACC_W      = DELAY_W + IDX_W + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic [IDX_W-1:0]          wrIdx,
  input  logic signed [DELAY_W-1:0] wrData,
  input  logic                      start,
  input  logic [NUM_STAGES-1:0]     challenge,
  input  logic [1:0]                mode,
  input  logic [IDX_W-1:0]          tapIdx,
  input  logic [IDX_W-1:0]          ffLo,
  input  logic [IDX_W-1:0]          ffHi,
  input  logic [NUM_STAGES-1:0]     skipMask,
  output logic                      busy,
  output logic                      done,
  output logic                      response,
  output logic signed [ACC_W-1:0]   delaySum
);

  ctrlStrobe_t      strobe;
  logic [IDX_W-1:0] stageIdx;

  arb_puf_emu_ctrl #(
    .NUM_STAGES(NUM_STAGES),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobe  (strobe),
    .stageIdx(stageIdx),
    .busy    (busy),
    .done    (done)
  );

  arb_puf_emu_dp #(
    .NUM_STAGES(NUM_STAGES),
    .DELAY_W   (DELAY_W),
    .IDX_W     (IDX_W),
    .ACC_W     (ACC_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .stageIdx (stageIdx),
    .wrEn     (wrEn),
    .wrIdx    (wrIdx),
    .wrData   (wrData),
    .challenge(challenge),
    .mode     (mode),
    .tapIdx   (tapIdx),
    .ffLo     (ffLo),
    .ffHi     (ffHi),
    .skipMask (skipMask),
    .response (response),
    .delaySum (delaySum)
  );

endmodule

// File: rtl/arb_puf_emu_chk.sv
module arb_puf_emu_chk #(
  parameter int ACC_W = 23
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic                    response,
  input logic signed [ACC_W-1:0] delaySum
);

  // R4: done lasts a single cycle
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: done marks the end of a run
  a_r4_done_ends_run: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R3: response agrees with the sign of the reported total
  a_r3_sign_match: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (response == (delaySum >= 0)));

  // R5: a start during a run never ends the run early
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> (busy || done));

  // R11: results hold while idle
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(delaySum) && $stable(response)));

endmodule

bind arb_puf_emu arb_puf_emu_chk #(.ACC_W(ACC_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .response(response),
  .delaySum(delaySum)
);

// File: tb/arb_puf_emu_tb.sv
`timescale 1ns/1ps
module arb_puf_emu_tb;

  localparam int N     = 64;
  localparam int IW    = 6;
  localparam int DW    = 16;
  localparam int AW    = DW + IW + 1;
  localparam int NV    = 10;

  typedef struct packed {
    logic [1:0]   mode;
    logic [N-1:0] ch;
    logic [IW-1:0] tap;
    logic [IW-1:0] lo;
    logic [IW-1:0] hi;
    logic [N-1:0] skip;
  } vec_t;

  // stimulus table; expected totals come from the bench model of R2/R6/R7/R8
  localparam vec_t VECS [NV] = '{
    '{2'd0, 64'h0,                   6'd0,  6'd0,  6'd0,  64'h0},
    '{2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0,  6'd0,  6'd0,  64'h0},
    '{2'd0, 64'hA5A5_0F0F_3C3C_FF00, 6'd0,  6'd0,  6'd0,  64'h0},
    '{2'd1, 64'h0123_4567_89AB_CDEF, 6'd10, 6'd20, 6'd40, 64'h0},
    '{2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 6'd31, 6'd32, 6'd63, 64'h0},
    '{2'd1, 64'hDEAD_BEEF_0000_FFFF, 6'd10, 6'd5,  6'd30, 64'h0},
    '{2'd1, 64'h5555_AAAA_5555_AAAA, 6'd3,  6'd20, 6'd10, 64'h0},
    '{2'd2, 64'h1234_5678_9ABC_DEF0, 6'd0,  6'd0,  6'd0,  64'hFFFF_0000_FFFF_0000},
    '{2'd2, 64'hCAFE_F00D_1357_2468, 6'd0,  6'd0,  6'd0,  64'hFFFF_FFFF_FFFF_FFFF},
    '{2'd3, 64'hA5A5_0F0F_3C3C_FF00, 6'd0,  6'd0,  6'd0,  64'h0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [IW-1:0] wrIdx = '0;
  logic signed [DW-1:0] wrData = '0;
  logic start = 1'b0;
  logic [N-1:0] challenge = '0;
  logic [1:0] mode = '0;
  logic [IW-1:0] tapIdx = '0, ffLo = '0, ffHi = '0;
  logic [N-1:0] skipMask = '0;
  logic busy, done, response;
  logic signed [AW-1:0] delaySum;

  int total = 0;
  int bad = 0;
  longint dly [N];

  always #2 clk = ~clk;

  arb_puf_emu #(.NUM_STAGES(N), .DELAY_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .start(start), .challenge(challenge), .mode(mode), .tapIdx(tapIdx),
    .ffLo(ffLo), .ffHi(ffHi), .skipMask(skipMask),
    .busy(busy), .done(done), .response(response), .delaySum(delaySum)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint model(input vec_t v);
    longint acc = 0;
    bit dec = 1'b0;
    bit ffOk = (v.mode == 2'd1) && (v.lo > v.tap) && (v.hi >= v.lo);
    for (int i = 0; i < N; i++) begin
      bit sel = v.ch[i];
      if (ffOk && i >= int'(v.lo) && i <= int'(v.hi)) sel = dec;
      if (!(v.mode == 2'd2 && v.skip[i])) acc += sel ? -dly[i] : dly[i];
      if (i == int'(v.tap)) dec = (acc >= 0);
    end
    return acc;
  endfunction

  task automatic writeStage(input int idx, input longint val);
    wrEn = 1'b1; wrIdx = IW'(idx); wrData = DW'(val);
    @(negedge clk);
    wrEn = 1'b0;
    dly[idx] = val;
  endtask

  task automatic applyVec(input vec_t v);
    challenge = v.ch; mode = v.mode; tapIdx = v.tap;
    ffLo = v.lo; ffHi = v.hi; skipMask = v.skip;
  endtask

  // start a run and wait for done; returns cycle count from accepting edge
  task automatic runOne(input vec_t v, output longint sum, output bit resp, output int lat);
    applyVec(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    sum = longint'(delaySum);
    resp = response;
  endtask

  task automatic runCheck(input vec_t v, input longint exp, input string tag);
    longint s; bit r; int lat;
    runOne(v, s, r, lat);
    chk(s == exp, tag, s, exp);
    chk(r == (exp >= 0), {tag, " R3 response"}, longint'(r), longint'(exp >= 0));
    chk(lat == N, "R4 latency", lat, N);
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    vec_t v;
    longint s, e; bit r; int lat;
    for (int i = 0; i < N; i++) dly[i] = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1 busy/done", longint'({busy, done}), 0);
    chk(response == 0 && delaySum == 0, "R1 result", longint'(delaySum), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1 delays read 0, R3 exact zero is positive
    runCheck(VECS[2], 0, "R1 R3 zero table");

    // R9 load table
    for (int i = 0; i < N; i++) writeStage(i, ((i * 37) % 101) - 50);

    // R2 R6 R7 R8 table walk
    for (int k = 0; k < NV; k++) begin
      e = model(VECS[k]);
      runCheck(VECS[k], e, $sformatf("R2/R6/R7/R8 vec%0d", k));
    end
    // R7 fallback equals plain total
    v = VECS[5]; v.mode = 2'd0;
    e = model(v);
    v = VECS[5];
    runCheck(v, e, "R7 lo<=tap fallback");
    v = VECS[6]; v.mode = 2'd0;
    e = model(v);
    v = VECS[6];
    runCheck(v, e, "R7 hi<lo fallback");
    // R8 full skip gives zero
    runCheck(VECS[8], 0, "R8 all skipped");

    // R6 hand-worked: all delays 1, tap 0, window 1..63
    for (int i = 0; i < N; i++) writeStage(i, 1);
    v = '{2'd1, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 6'd1, 6'd63, 64'h0};
    runCheck(v, 62, "R6 negative tap");
    v.ch = 64'hFFFF_FFFF_FFFF_FFFE;
    runCheck(v, -62, "R6 positive tap");
    v.mode = 2'd0;
    runCheck(v, -62, "R2 plain ref");

    // R3 negative by one
    for (int i = 0; i < N; i++) writeStage(i, 0);
    writeStage(7, -1);
    v = '{2'd0, 64'h0, 6'd0, 6'd0, 6'd0, 64'h0};
    runCheck(v, -1, "R3 minus one");

    // R10 extremes
    for (int i = 0; i < N; i++) writeStage(i, -32768);
    v = '{2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 6'd0, 6'd0, 64'h0};
    runCheck(v, 2097152, "R10 max positive");
    v.ch = 64'h0;
    runCheck(v, -2097152, "R10 max negative");

    // R5 R11 R9: restart, config changes and writes while busy
    for (int i = 0; i < N; i++) writeStage(i, ((i * 13) % 29) - 14);
    v = '{2'd0, 64'h0F0F_F0F0_1234_4321, 6'd0, 6'd0, 6'd0, 64'h0};
    e = model(v);
    applyVec(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
      if (lat == 5) begin
        start = 1'b1; challenge = ~v.ch; mode = 2'd2; skipMask = '1;
        wrEn = 1'b1; wrIdx = 6'd60; wrData = 16'sd9999;
      end
      if (lat == 6) begin
        start = 1'b0; wrEn = 1'b0;
      end
    end
    s = longint'(delaySum);
    chk(s == e, "R5 R11 run unaffected", s, e);
    chk(lat == N, "R5 no restart latency", lat, N);
    begin
      int extra = 0;
      for (int c = 0; c < N + 4; c++) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk(extra == 0, "R5 single done", extra, 0);
      chk(longint'(delaySum) == e, "R11 idle hold", longint'(delaySum), e);
    end
    // R9 busy write ignored: stage 60 keeps its old delay
    v.ch = 64'h0; v.mode = 2'd2; v.skip = ~(64'h1 << 60);
    runOne(v, s, r, lat);
    chk(s == dly[60], "R9 busy write ignored", s, dly[60]);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule